// File: doc/BRIEF.md
# Banked Cartridge Memory Controller with Real-Time Clock Snapshot

This block sits between a CPU bus with a 16-bit address and the ROM, the external RAM and a small real-time clock on a cartridge. Writes into the read-only address space do not reach the ROM. They program control state instead: a RAM enable flag, a 7-bit ROM bank number, a RAM bank selector and a clock snapshot command. Reads in the switchable ROM window are steered to the selected bank. Accesses in the external RAM window go either to a RAM bank or, when the selector holds a clock code, to one of five clock registers.

The clock keeps seconds, minutes, hours and a 9-bit day count, and it advances on a one-cycle tick. Software reads the clock coherently by issuing a snapshot command. This copies the running registers into a held set and routes later clock reads to that copy until the command is withdrawn. Every read returns its data one cycle after the request. The block registers the memory address and strobes, and the attached memories answer combinationally from that registered address.

Top module: `cart_bank_rtc`

## Requirements
- R1: After reset the ROM bank is 1, the RAM bank selector is 0, RAM enable is 0, the snapshot flag is clear, and all live and held clock registers are 0.
- R2: A write anywhere in 0x0000–0x1FFF sets `ram_en` to 1 when the byte is 0x0A, and clears it for any other byte.
- R3: A write in 0x2000–0x3FFF loads the ROM bank with the low 7 bits of the byte, and a value of 0 is stored as 1. A read at 0x0000–0x3FFF drives `rom_addr` = address. A read at 0x4000–0x7FFF drives `rom_addr` = bank × 0x4000 + (address − 0x4000).
- R4: A read in 0x4000–0x7FFF while the ROM bank is ≥ ROM_BANKS (default 64) returns 0 and does not raise `rom_rd`.
- R5: A write in 0x4000–0x5FFF stores byte & 0x03 as the RAM bank. When the clock is present and the byte is 0x08–0x0C, the whole byte is stored instead and selects clock register (byte − 0x08). The clock registers are, in index order 0 to 4: seconds, minutes, hours, day bits 7:0, and day bit 8 in bit 0.
- R6: An access in 0xA000–0xBFFF with a RAM bank selected uses `ram_addr` = bank × 0x2000 + (address − 0xA000). Writes take place whatever the value of `ram_en`.
- R7: With a RAM bank ≥ RAM_BANKS (default 2) selected, reads in 0xA000–0xBFFF return 0 and writes raise no `ram_we`.
- R8: A write in 0xA000–0xBFFF with a clock register selected stores the byte into that live register and leaves RAM unchanged.
- R9: Each `rtc_tick` advances the live clock. Seconds and minutes wrap from 59 to 0, hours wrap from 23 to 0, and the day count wraps from 511 to 0. Each wrap carries into the next field.
- R10: A write in 0x6000–0x7FFF with bit 0 = 1 copies the live clock into the held set and sets the snapshot flag. Clock reads then return held values while ticks continue. A write with bit 0 = 0 clears the flag, and clock reads return live values again.
- R11: `rd_valid` is high exactly one cycle after each `bus_rd`. A read in 0x8000–0x9FFF or 0xC000–0xFFFF returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write request for one cycle |
| bus_rd | input | 1 | Bus read request for one cycle |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Bus write byte |
| rtc_tick | input | 1 | One-cycle pulse, one per second |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 8 | Read response byte |
| rom_rd | output | 1 | ROM read strobe (registered) |
| rom_addr | output | ROM_BW+14 | ROM byte address (registered) |
| rom_rdata | input | 8 | ROM byte for `rom_addr` |
| ram_rd | output | 1 | RAM read strobe (registered) |
| ram_we | output | 1 | RAM write strobe (registered) |
| ram_addr | output | RAM_BW+13 | RAM byte address (registered) |
| ram_wdata | output | 8 | RAM write byte (registered) |
| ram_rdata | input | 8 | RAM byte for `ram_addr` |
| ram_en | output | 1 | RAM enable flag |

## Verification
The assertions take for granted that `bus_rd` and `bus_wr` are never high in the same cycle. They also assume that `rtc_tick` is a single-cycle pulse and that the memories answer within the cycle after the registered address. The directed stimulus drives each bus request for exactly one cycle from the falling edge and leaves the bus idle in between. It never pulses the tick while a clock register is being written. Clock values written by the stimulus stay within their counting ranges, except where a wrap boundary is the target.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_ROM  = 2'd1,
    SRC_RAM  = 2'd2,
    SRC_CLK  = 2'd3
  } rsp_src_e;

  // 8 KiB windows, picked by address bits 15:13
  localparam logic [2:0] WIN_ENABLE  = 3'd0;
  localparam logic [2:0] WIN_ROMSEL  = 3'd1;
  localparam logic [2:0] WIN_BANKSEL = 3'd2;
  localparam logic [2:0] WIN_LATCH   = 3'd3;
  localparam logic [2:0] WIN_EXTRAM  = 3'd5;

  localparam logic [7:0] ENABLE_KEY = 8'h0A;
  localparam logic [7:0] CLK_SEL_LO = 8'h08;
  localparam logic [7:0] CLK_SEL_HI = 8'h0C;

  typedef struct packed {
    logic [8:0] day;
    logic [4:0] hr;
    logic [5:0] min;
    logic [5:0] sec;
  } clk_time_t;

  function automatic logic [7:0] clk_byte(input clk_time_t t, input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0:    b = {2'b00, t.sec};
      3'd1:    b = {2'b00, t.min};
      3'd2:    b = {3'b000, t.hr};
      3'd3:    b = t.day[7:0];
      3'd4:    b = {7'b0000000, t.day[8]};
      default: b = 8'h00;
    endcase
    return b;
  endfunction

  function automatic clk_time_t clk_advance(input clk_time_t t);
    clk_time_t n;
    logic      s_wrap, m_wrap, h_wrap;
    n      = t;
    s_wrap = (t.sec >= 6'd59);
    m_wrap = (t.min >= 6'd59);
    h_wrap = (t.hr  >= 5'd23);
    n.sec  = s_wrap ? 6'd0 : t.sec + 6'd1;
    if (s_wrap)
      n.min = m_wrap ? 6'd0 : t.min + 6'd1;
    if (s_wrap && m_wrap)
      n.hr = h_wrap ? 5'd0 : t.hr + 5'd1;
    if (s_wrap && m_wrap && h_wrap)
      n.day = t.day + 9'd1;
    return n;
  endfunction

endpackage

// File: rtl/cbr_ctl.sv
module cbr_ctl
  import cbr_pkg::*;
#(
  parameter int ROM_BW    = 7,
  parameter bit HAS_CLOCK = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        win,
  input  logic [7:0]        wdata,
  output logic              ram_en,
  output logic [ROM_BW-1:0] rom_bank,
  output logic [3:0]        bank_sel,
  output logic              latched,
  output logic              snap,
  output logic              clk_wr,
  output logic              is_clk_sel
);

  logic              clk_code;
  logic [ROM_BW-1:0] rom_req;

  assign clk_code   = HAS_CLOCK && (wdata >= CLK_SEL_LO) && (wdata <= CLK_SEL_HI);
  assign rom_req    = wdata[ROM_BW-1:0];
  assign is_clk_sel = HAS_CLOCK && bank_sel[3];
  assign snap       = wr_en && (win == WIN_LATCH) && wdata[0];
  assign clk_wr     = wr_en && (win == WIN_EXTRAM) && is_clk_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_en   <= 1'b0;
      rom_bank <= ROM_BW'(1);
      bank_sel <= 4'd0;
      latched  <= 1'b0;
    end else if (wr_en) begin
      case (win)
        WIN_ENABLE:  ram_en   <= (wdata == ENABLE_KEY);
        WIN_ROMSEL:  rom_bank <= (rom_req == '0) ? ROM_BW'(1) : rom_req;
        WIN_BANKSEL: bank_sel <= clk_code ? wdata[3:0] : {2'b00, wdata[1:0]};
        WIN_LATCH:   latched  <= wdata[0];
        default: ;
      endcase
    end
  end

  // R3: the ROM bank never reads as zero
  a_r3_bank_nonzero: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rom_bank != '0));

  // R5: selector holds only a RAM bank code or a clock code
  a_r5_sel_legal: assert property (@(posedge clk) disable iff (rst)
    (bank_sel <= 4'd3) || ((bank_sel >= 4'd8) && (bank_sel <= 4'd12)));

  // R2: enable follows the key byte
  a_r2_enable_key: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (win == WIN_ENABLE)) |=> (ram_en == ($past(wdata) == ENABLE_KEY)));

endmodule

// File: rtl/cbr_rtc.sv
module cbr_rtc
  import cbr_pkg::*;
#(
  parameter bit HAS_CLOCK = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [2:0] idx,
  input  logic [7:0] wdata,
  input  logic       snap,
  input  logic       latched,
  output logic [7:0] rd_byte
);

  generate
    if (HAS_CLOCK) begin : g_clk
      clk_time_t live, held;

      always_ff @(posedge clk) begin
        if (rst) begin
          live <= '0;
          held <= '0;
        end else begin
          if (wr_en) begin
            case (idx)
              3'd0: live.sec      <= wdata[5:0];
              3'd1: live.min      <= wdata[5:0];
              3'd2: live.hr       <= wdata[4:0];
              3'd3: live.day[7:0] <= wdata;
              3'd4: live.day[8]   <= wdata[0];
              default: ;
            endcase
          end else if (tick) begin
            live <= clk_advance(live);
          end
          if (snap)
            held <= live;
        end
      end

      assign rd_byte = clk_byte(latched ? held : live, idx);

      // R10: held copy changes only on a snapshot command
      a_r10_held_stable: assert property (@(posedge clk) disable iff (rst)
        !snap |=> $stable(held));

      // R9: counting keeps seconds in range
      a_r9_sec_range: assert property (@(posedge clk) disable iff (rst)
        ((live.sec < 6'd60) && !wr_en) |=> (live.sec < 6'd60));

      // R9: counting keeps hours in range
      a_r9_hr_range: assert property (@(posedge clk) disable iff (rst)
        ((live.hr < 5'd24) && !wr_en) |=> (live.hr < 5'd24));

      // R8: a seconds write lands in the live seconds register
      a_r8_sec_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (idx == 3'd0)) |=> (live.sec == $past(wdata[5:0])));
    end else begin : g_noclk
      assign rd_byte = 8'h00;
    end
  endgenerate

endmodule

// File: rtl/cbr_map.sv
module cbr_map
  import cbr_pkg::*;
#(
  parameter int ROM_BW    = 7,
  parameter int ROM_BANKS = 64,
  parameter int RAM_BW    = 1,
  parameter int RAM_BANKS = 2,
  localparam int ROM_AW   = ROM_BW + 14,
  localparam int RAM_AW   = RAM_BW + 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [15:0]       addr,
  input  logic [7:0]        wdata,
  input  logic [ROM_BW-1:0] rom_bank,
  input  logic [3:0]        bank_sel,
  input  logic              is_clk_sel,
  input  logic [7:0]        clk_byte_in,
  output logic              rd_valid,
  output rsp_src_e          src,
  output logic [7:0]        clk_q,
  output logic              rom_rd,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              ram_rd,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata
);

  localparam logic [ROM_BW:0] ROM_LIM = (ROM_BW + 1)'(ROM_BANKS);
  localparam logic [4:0]      RAM_LIM = 5'(RAM_BANKS);

  logic rom_ok, ram_ok, in_ram_win;

  assign rom_ok     = ({1'b0, rom_bank} < ROM_LIM);
  assign ram_ok     = !is_clk_sel && ({1'b0, bank_sel} < RAM_LIM);
  assign in_ram_win = (addr[15:13] == WIN_EXTRAM);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid  <= 1'b0;
      src       <= SRC_NONE;
      clk_q     <= 8'h00;
      rom_rd    <= 1'b0;
      rom_addr  <= '0;
      ram_rd    <= 1'b0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= 8'h00;
    end else begin
      rd_valid <= rd_en;
      rom_rd   <= 1'b0;
      ram_rd   <= 1'b0;
      ram_we   <= 1'b0;
      src      <= SRC_NONE;
      if (rd_en) begin
        if (!addr[15]) begin
          if (!addr[14]) begin
            rom_rd   <= 1'b1;
            src      <= SRC_ROM;
            rom_addr <= {{ROM_BW{1'b0}}, addr[13:0]};
          end else if (rom_ok) begin
            rom_rd   <= 1'b1;
            src      <= SRC_ROM;
            rom_addr <= {rom_bank, addr[13:0]};
          end
        end else if (in_ram_win) begin
          if (is_clk_sel) begin
            src   <= SRC_CLK;
            clk_q <= clk_byte_in;
          end else if (ram_ok) begin
            ram_rd   <= 1'b1;
            src      <= SRC_RAM;
            ram_addr <= {bank_sel[RAM_BW-1:0], addr[12:0]};
          end
        end
      end else if (wr_en && in_ram_win && ram_ok) begin
        ram_we    <= 1'b1;
        ram_addr  <= {bank_sel[RAM_BW-1:0], addr[12:0]};
        ram_wdata <= wdata;
      end
    end
  end

  // R11: one response per read request, one cycle later
  a_r11_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  // R7: no RAM write strobe for an unbacked bank or a clock select
  a_r7_oob_no_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && in_ram_win && !ram_ok) |=> !ram_we);

  // R4: ROM strobe never points at a bank beyond the limit
  a_r4_rom_limit: assert property (@(posedge clk) disable iff (rst)
    rom_rd |-> ({1'b0, rom_addr[ROM_AW-1:14]} < ROM_LIM));

  // R6: the memory strobes are mutually exclusive
  a_r6_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    $countones({rom_rd, ram_rd, ram_we}) <= 1);

endmodule

// File: rtl/cart_bank_rtc.sv
module cart_bank_rtc
  import cbr_pkg::*;
#(
  parameter int ROM_BW    = 7,
  parameter int ROM_BANKS = 64,
  parameter int RAM_BANKS = 2,
  parameter bit HAS_CLOCK = 1'b1,
  localparam int RAM_BW   = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1,
  localparam int ROM_AW   = ROM_BW + 14,
  localparam int RAM_AW   = RAM_BW + 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [15:0]       bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              rtc_tick,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              rom_rd,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [7:0]        rom_rdata,
  output logic              ram_rd,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata,
  output logic              ram_en
);

  logic [ROM_BW-1:0] rom_bank;
  logic [3:0]        bank_sel;
  logic              latched, snap, clk_wr, is_clk_sel;
  logic [7:0]        clk_byte_now, clk_q;
  rsp_src_e          src;

  cbr_ctl #(.ROM_BW(ROM_BW), .HAS_CLOCK(HAS_CLOCK)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (bus_wr),
    .win       (bus_addr[15:13]),
    .wdata     (bus_wdata),
    .ram_en    (ram_en),
    .rom_bank  (rom_bank),
    .bank_sel  (bank_sel),
    .latched   (latched),
    .snap      (snap),
    .clk_wr    (clk_wr),
    .is_clk_sel(is_clk_sel)
  );

  cbr_rtc #(.HAS_CLOCK(HAS_CLOCK)) u_rtc (
    .clk    (clk),
    .rst    (rst),
    .tick   (rtc_tick),
    .wr_en  (clk_wr),
    .idx    (bank_sel[2:0]),
    .wdata  (bus_wdata),
    .snap   (snap),
    .latched(latched),
    .rd_byte(clk_byte_now)
  );

  cbr_map #(
    .ROM_BW   (ROM_BW),
    .ROM_BANKS(ROM_BANKS),
    .RAM_BW   (RAM_BW),
    .RAM_BANKS(RAM_BANKS)
  ) u_map (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (bus_rd),
    .wr_en      (bus_wr),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .rom_bank   (rom_bank),
    .bank_sel   (bank_sel),
    .is_clk_sel (is_clk_sel),
    .clk_byte_in(clk_byte_now),
    .rd_valid   (rd_valid),
    .src        (src),
    .clk_q      (clk_q),
    .rom_rd     (rom_rd),
    .rom_addr   (rom_addr),
    .ram_rd     (ram_rd),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata)
  );

  always_comb begin
    case (src)
      SRC_ROM: rd_data = rom_rdata;
      SRC_RAM: rd_data = ram_rdata;
      SRC_CLK: rd_data = clk_q;
      default: rd_data = 8'h00;
    endcase
  end

  // R11: a response with no backing source reads as zero
  a_r11_zero_fill: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rom_rd && !ram_rd && (src != SRC_CLK)) |-> (rd_data == 8'h00));

endmodule

// File: tb/sim_cart_bank_rtc.sv
module sim_cart_bank_rtc;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, rtc_tick = 1'b0;
  logic [15:0] bus_addr = 16'h0;
  logic [7:0]  bus_wdata = 8'h0;
  logic        rd_valid, rom_rd, ram_rd, ram_we, ram_en;
  logic [7:0]  rd_data, rom_rdata, ram_rdata, ram_wdata;
  logic [20:0] rom_addr;
  logic [13:0] ram_addr;

  logic [7:0]  tb_ram [0:255];
  int          n_chk = 0, n_bad = 0;
  logic        s_valid, s_rom_rd;
  logic [7:0]  s_data;
  logic [20:0] s_rom_addr;
  logic [13:0] s_ram_addr;

  always #10 clk = ~clk;

  cart_bank_rtc u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rtc_tick(rtc_tick),
    .rd_valid(rd_valid), .rd_data(rd_data), .rom_rd(rom_rd),
    .rom_addr(rom_addr), .rom_rdata(rom_rdata), .ram_rd(ram_rd),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .ram_en(ram_en)
  );

  // behavioural memories: ROM content is a function of its address
  assign rom_rdata = rom_addr[7:0] ^ {1'b0, rom_addr[20:14]};
  assign ram_rdata = tb_ram[{ram_addr[13], ram_addr[6:0]}];
  always @(posedge clk)
    if (ram_we) tb_ram[{ram_addr[13], ram_addr[6:0]}] <= ram_wdata;

  initial for (int i = 0; i < 256; i++) tb_ram[i] = 8'h00;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    s_valid = rd_valid; s_data = rd_data; s_rom_rd = rom_rd;
    s_rom_addr = rom_addr; s_ram_addr = ram_addr;
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rtc_tick = 1'b1;
      @(negedge clk); rtc_tick = 1'b0;
    end
  endtask

  task automatic clk_reg_read(input int k, output logic [7:0] v);
    bus_write(16'h4000, 8'(8 + k));
    bus_read(16'hA000);
    v = s_data;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 ram_en after reset", 32'(ram_en), 0);
    chk("R1 idle rd_valid", 32'(rd_valid), 0);
    bus_read(16'h4000);
    chk("R1 rom bank 1 address", 32'(s_rom_addr), 32'h04000);
    chk("R1 rom bank 1 data", 32'(s_data), 32'h01);
    bus_read(16'hA000);
    chk("R1 ram bank 0 address", 32'(s_ram_addr), 0);
    for (int k = 0; k < 5; k++) begin
      clk_reg_read(k, v);
      chk("R1 clock register zero", 32'(v), 0);
    end
    bus_write(16'h4000, 8'h00);
  endtask

  task automatic t_enable;
    bus_write(16'h0000, 8'h0A);
    chk("R2 enable key", 32'(ram_en), 1);
    bus_write(16'h0000, 8'h0B);
    chk("R2 non-key clears", 32'(ram_en), 0);
    bus_write(16'h1FFF, 8'h0A);
    chk("R2 top of window", 32'(ram_en), 1);
    bus_write(16'h0000, 8'h00);
  endtask

  task automatic t_rom_bank;
    bus_write(16'h2000, 8'h85);
    bus_read(16'h4123);
    chk("R3 bank 5 address", 32'(s_rom_addr), 32'h14123);
    chk("R3 bank 5 data", 32'(s_data), 32'h23 ^ 32'h05);
    bus_write(16'h3FFF, 8'h80);
    bus_read(16'h7FFF);
    chk("R3 zero becomes 1", 32'(s_rom_addr), 32'h07FFF);
    bus_read(16'h1234);
    chk("R3 fixed bank address", 32'(s_rom_addr), 32'h01234);
  endtask

  task automatic t_rom_limit;
    bus_write(16'h2000, 8'h3F);
    bus_read(16'h4005);
    chk("R4 last bank address", 32'(s_rom_addr), 32'hFC005);
    chk("R4 last bank data", 32'(s_data), 32'h3A);
    bus_write(16'h2000, 8'h40);
    bus_read(16'h4005);
    chk("R4 beyond limit data", 32'(s_data), 0);
    chk("R4 beyond limit strobe", 32'(s_rom_rd), 0);
    bus_write(16'h2000, 8'h01);
  endtask

  task automatic t_ram;
    bus_write(16'h4000, 8'h00);
    bus_write(16'hA010, 8'h11);
    bus_write(16'h4000, 8'h01);
    bus_write(16'hA010, 8'h22);
    bus_read(16'hA010);
    chk("R6 bank 1 data (enable off)", 32'(s_data), 32'h22);
    chk("R6 bank 1 address", 32'(s_ram_addr), 32'h2010);
    bus_write(16'h4000, 8'h00);
    bus_read(16'hA010);
    chk("R6 bank 0 data", 32'(s_data), 32'h11);
    chk("R6 bank 0 address", 32'(s_ram_addr), 32'h0010);
  endtask

  task automatic t_bank_select;
    bus_write(16'h4000, 8'h05);
    bus_read(16'hA010);
    chk("R5 0x05 selects bank 1", 32'(s_data), 32'h22);
    bus_write(16'h5FFF, 8'h0D);
    bus_read(16'hA010);
    chk("R5 0x0D selects bank 1", 32'(s_data), 32'h22);
  endtask

  task automatic t_ram_oob;
    bus_write(16'h4000, 8'h02);
    bus_read(16'hA010);
    chk("R7 bank 2 reads zero", 32'(s_data), 0);
    bus_write(16'hA010, 8'h77);
    bus_write(16'h4000, 8'h03);
    bus_read(16'hA010);
    chk("R7 bank 3 reads zero", 32'(s_data), 0);
    bus_write(16'h4000, 8'h00);
    bus_read(16'hA010);
    chk("R7 no aliased write", 32'(s_data), 32'h11);
  endtask

  task automatic t_clock_write;
    logic [7:0] v;
    bus_write(16'h4000, 8'h08);
    bus_write(16'hA010, 8'h2A);
    bus_write(16'h4000, 8'h0C);
    bus_write(16'hA000, 8'hFF);
    clk_reg_read(0, v);
    chk("R8 seconds written", 32'(v), 32'h2A);
    clk_reg_read(4, v);
    chk("R8 day bit 8 written", 32'(v), 32'h01);
    bus_write(16'h4000, 8'h00);
    bus_read(16'hA010);
    chk("R8 RAM untouched", 32'(s_data), 32'h11);
  endtask

  task automatic set_clock(input logic [7:0] s, m, h, dl, dh);
    bus_write(16'h4000, 8'h08); bus_write(16'hA000, s);
    bus_write(16'h4000, 8'h09); bus_write(16'hA000, m);
    bus_write(16'h4000, 8'h0A); bus_write(16'hA000, h);
    bus_write(16'h4000, 8'h0B); bus_write(16'hA000, dl);
    bus_write(16'h4000, 8'h0C); bus_write(16'hA000, dh);
  endtask

  task automatic t_clock_count;
    logic [7:0] v;
    set_clock(8'd5, 8'd0, 8'd0, 8'd0, 8'd0);
    tick_n(2);
    clk_reg_read(0, v);
    chk("R9 seconds count", 32'(v), 7);
    set_clock(8'd59, 8'd59, 8'd23, 8'hFF, 8'h00);
    tick_n(1);
    clk_reg_read(0, v); chk("R9 seconds wrap", 32'(v), 0);
    clk_reg_read(1, v); chk("R9 minutes wrap", 32'(v), 0);
    clk_reg_read(2, v); chk("R9 hours wrap", 32'(v), 0);
    clk_reg_read(3, v); chk("R9 day low carry", 32'(v), 0);
    clk_reg_read(4, v); chk("R9 day bit 8 set", 32'(v), 1);
    set_clock(8'd59, 8'd59, 8'd23, 8'hFF, 8'h01);
    tick_n(1);
    clk_reg_read(4, v); chk("R9 day 511 wraps", 32'(v), 0);
    clk_reg_read(3, v); chk("R9 day low after wrap", 32'(v), 0);
  endtask

  task automatic t_latch;
    logic [7:0] v;
    set_clock(8'd10, 8'd0, 8'd0, 8'd0, 8'd0);
    bus_write(16'h6000, 8'h01);
    tick_n(3);
    clk_reg_read(0, v);
    chk("R10 held seconds", 32'(v), 10);
    bus_write(16'h7FFF, 8'h00);
    clk_reg_read(0, v);
    chk("R10 live seconds", 32'(v), 13);
  endtask

  task automatic t_unmapped;
    @(negedge clk);
    chk("R11 no read no valid", 32'(rd_valid), 0);
    bus_read(16'h8000);
    chk("R11 valid after read", 32'(s_valid), 1);
    chk("R11 0x8000 reads zero", 32'(s_data), 0);
    bus_read(16'hC123);
    chk("R11 0xC123 reads zero", 32'(s_data), 0);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_enable();
    t_rom_bank();
    t_rom_limit();
    t_ram();
    t_bank_select();
    t_ram_oob();
    t_clock_write();
    t_clock_count();
    t_latch();
    t_unmapped();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule